// File: doc/BRIEF.md
# Push-Pull Gate Drive Sequencer

This block generates the two gate-drive phases for a center-tapped transformer driver, running entirely from a fast system clock. The switching reference comes from one of two places. The first is an internal reference, built as a programmable half-period counter whose length is swept up and down by a triangular dither. The second is an external synchronisation clock. The chosen reference is divided by two into complementary phases. Before either gate is allowed high, both gates are held low for a programmable dead time.

The external clock is synchronised into the system domain and watched by a timeout counter. When it stops, the block falls back to the internal reference. It only returns to external timing after a run of consecutive, timely external edges. Source changes are applied only at an internal phase boundary. Dithering is suspended whenever the external clock drives the phases.

An enable input and an undervoltage flag gate the whole output path. When the path is off, both gates are low and the drive-enable output, which controls the high-impedance state of the power stage, is released. On every activation, a soft-start level ramps from zero to full scale in fixed steps.

Top module: `pp_gate_seq`

## Requirements
- R1: The gates alternate: after a rising edge of `g1`, the next gate to rise is `g2`, and the other way round. Each phase starts at a tick of the selected reference, so the selected reference is divided by two.
- R2: While `clk_src` is 1, every synchronised rising edge of `ext_clk` ends the current phase. With an external period of P system clocks, each gate stays high for exactly P - DEAD_CYC - 1 cycles.
- R3: `g1` and `g2` are never high in the same cycle. Before either gate rises, both have been low for at least DEAD_CYC + 1 consecutive cycles.
- R4: If no synchronised `ext_clk` rising edge arrives for EXT_TIMEOUT system clocks, `clk_src` returns to 0 at the next internal phase boundary. Before the timeout expires, `clk_src` stays 1. After fallback, the gates keep switching.
- R5: `clk_src` becomes 1 only after RELOCK_EDGES consecutive `ext_clk` rising edges, each arriving within EXT_TIMEOUT of the one before. The change takes effect at an internal phase boundary. A shorter train leaves `clk_src` at 0.
- R6: An internal half-period lasts BASE_HALF + offset system clocks. The offset moves by one at each full internal period, in a triangle between -DITHER_SPAN and +DITHER_SPAN. Consecutive gate high times therefore differ by at most one cycle, and they span from BASE_HALF - DITHER_SPAN - DEAD_CYC - 1 to BASE_HALF + DITHER_SPAN - DEAD_CYC - 1.
- R7: While `clk_src` is 1, the dither offset is held at zero.
- R8: Consider the case where `en` is low or `uvlo` is high. `drive_en` is 0 after the next rising clock edge. By the second edge, `g1`, `g2` and `ss_level` are 0, and they stay there until the block is re-activated.
- R9: After activation, `ss_level` rises by one every SS_STEP cycles, with no other change. It first reaches full scale (all ones) exactly SS_STEP × (2^SS_W - 1) + 1 cycles after the input change, and then holds there.
- R10: During and just after reset, `g1`, `g2`, `drive_en`, `ss_level` and `clk_src` are all 0.
- R11: `clk_src` encodes the active reference: 0 is internal, 1 is external.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| uvlo | input | 1 | Undervoltage flag; high forces the outputs off |
| ext_clk | input | 1 | External synchronisation clock, asynchronous |
| g1 | output | 1 | Gate drive, first phase |
| g2 | output | 1 | Gate drive, second phase |
| drive_en | output | 1 | Power stage enable; 0 means high impedance |
| ss_level | output | SS_W | Soft-start drive level |
| clk_src | output | 1 | Active reference, 0 internal, 1 external |

## Verification
Two situations are hard to reach from the ports. The first is the return to external timing after a fallback, since it depends on how many edges arrived and on the timeout history. The second is a train of external edges that is just too short to relock. The stimulus drives a counted external clock from the bench. It first relocks, then stops the clock to force the timeout, and then supplies exactly RELOCK_EDGES - 1 edges. The bench watches `clk_src` across that whole window. The dither extremes are reached by running the internal reference for more than one full triangle sweep, while recording the shortest and longest gate high times.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;

  // Length of one internal half-period for a given dither offset.
  function automatic int half_len(int base, int off);
    return base + off;
  endfunction

  // Next point on the dither triangle.
  function automatic int tri_step(int off, logic up, int span);
    if (span == 0) return 0;
    return up ? off + 1 : off - 1;
  endfunction

  // Direction after moving to 'nxt'; turns around at the span limits.
  function automatic logic tri_dir(int nxt, logic up, int span);
    if (nxt >= span) return 1'b0;
    if (nxt <= -span) return 1'b1;
    return up;
  endfunction

endpackage

// File: rtl/pgs_int_osc.sv
module pgs_int_osc
  import pgs_pkg::*;
#(
  parameter int BASE_HALF   = 20,
  parameter int DITHER_SPAN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_flat,
  output logic tick
);
  localparam int OFF_W = $clog2(DITHER_SPAN + 1) + 1;
  localparam int CNT_W = $clog2(BASE_HALF + DITHER_SPAN + 1);

  logic [CNT_W-1:0]        cnt_q, cnt_ld;
  logic signed [OFF_W-1:0] off_q, off_nx;
  logic                    up_q, up_nx, half_q;
  logic                    period_end;

  assign tick       = (cnt_q == '0);
  assign period_end = tick & half_q;

  always_comb begin
    off_nx = off_q;
    up_nx  = up_q;
    if (hold_flat) begin
      off_nx = '0;
      up_nx  = 1'b1;
    end else if (period_end) begin
      off_nx = OFF_W'(tri_step(int'(off_q), up_q, DITHER_SPAN));
      up_nx  = tri_dir(int'(off_nx), up_q, DITHER_SPAN);
    end
    cnt_ld = CNT_W'(half_len(BASE_HALF, int'(off_nx)) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(BASE_HALF - 1);
      off_q  <= '0;
      up_q   <= 1'b1;
      half_q <= 1'b0;
    end else begin
      off_q <= off_nx;
      up_q  <= up_nx;
      if (tick) begin
        cnt_q  <= cnt_ld;
        half_q <= ~half_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_DITHER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(off_q) <= DITHER_SPAN) && (int'(off_q) >= -DITHER_SPAN)); // R6
  AST_DITHER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != $past(off_q)) && !$past(hold_flat) |-> $past(period_end)); // R6
  AST_FLAT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_flat |=> (off_q == '0)); // R7

endmodule

// File: rtl/pgs_ext_mon.sv
module pgs_ext_mon #(
  parameter int EXT_TIMEOUT  = 64,
  parameter int RELOCK_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic ext_edge,
  output logic ext_req
);
  localparam int TW = $clog2(EXT_TIMEOUT + 1);
  localparam int GW = $clog2(RELOCK_EDGES + 1);

  logic          s1_q, s2_q, s3_q;
  logic [TW-1:0] gap_q;
  logic [GW-1:0] good_q;
  logic          timed_out;

  assign ext_edge  = s2_q & ~s3_q;
  assign timed_out = (gap_q == TW'(EXT_TIMEOUT));
  assign ext_req   = (good_q == GW'(RELOCK_EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      gap_q  <= '0;
      good_q <= '0;
    end else begin
      s1_q <= ext_clk;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (ext_edge)        gap_q <= '0;
      else if (!timed_out) gap_q <= gap_q + 1'b1;
      if (ext_edge) begin
        if (timed_out)    good_q <= GW'(1);
        else if (!ext_req) good_q <= good_q + 1'b1;
      end else if (timed_out) begin
        good_q <= '0;
      end
    end
  end

  AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out && !ext_edge |=> !ext_req); // R4
  AST_REQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_req) |-> $past(ext_edge)); // R5

endmodule

// File: rtl/pgs_bbm.sv
module pgs_bbm #(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic tick,
  output logic g1,
  output logic g2
);
  localparam int DW = $clog2(DEAD_CYC + 2);

  logic          ph_q;
  logic [DW-1:0] dcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      dcnt_q <= DW'(DEAD_CYC);
      g1     <= 1'b0;
      g2     <= 1'b0;
    end else if (!act) begin
      ph_q   <= 1'b0;
      dcnt_q <= DW'(DEAD_CYC);
      g1     <= 1'b0;
      g2     <= 1'b0;
    end else if (tick) begin
      ph_q   <= ~ph_q;
      dcnt_q <= DW'(DEAD_CYC);
      g1     <= 1'b0;
      g2     <= 1'b0;
    end else if (dcnt_q != '0) begin
      dcnt_q <= dcnt_q - 1'b1;
      g1     <= 1'b0;
      g2     <= 1'b0;
    end else begin
      g1 <= ~ph_q;
      g2 <= ph_q;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(g1 && g2)); // R3
  AST_GAP_G1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(g1) |-> !g2 && $past(!g2)); // R3
  AST_GAP_G2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(g2) |-> !g1 && $past(!g1)); // R3
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !g1 && !g2); // R8

endmodule

// File: rtl/pgs_softstart.sv
module pgs_softstart #(
  parameter int SS_STEP = 8,
  parameter int SS_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act,
  output logic [SS_W-1:0] level
);
  localparam int SW = $clog2(SS_STEP + 1);

  logic [SW-1:0] sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q  <= '0;
      level <= '0;
    end else if (!act) begin
      sc_q  <= '0;
      level <= '0;
    end else if (level != '1) begin
      if (sc_q == SW'(SS_STEP - 1)) begin
        sc_q  <= '0;
        level <= level + 1'b1;
      end else begin
        sc_q <= sc_q + 1'b1;
      end
    end
  end

  AST_SS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (level == '0)); // R8
  AST_SS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    act && $past(act) |-> (level == $past(level)) || (level == $past(level) + 1'b1)); // R9

endmodule

// File: rtl/pp_gate_seq.sv
module pp_gate_seq
  import pgs_pkg::*;
#(
  parameter int BASE_HALF    = 20,
  parameter int DITHER_SPAN  = 4,
  parameter int DEAD_CYC     = 3,
  parameter int EXT_TIMEOUT  = 64,
  parameter int RELOCK_EDGES = 3,
  parameter int SS_STEP      = 8,
  parameter int SS_W         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            uvlo,
  input  logic            ext_clk,
  output logic            g1,
  output logic            g2,
  output logic            drive_en,
  output logic [SS_W-1:0] ss_level,
  output logic            clk_src
);
  logic act_q;
  logic int_tick, ext_edge, ext_req, sel_tick;
  src_e src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= en & ~uvlo;
  end

  pgs_int_osc #(.BASE_HALF(BASE_HALF), .DITHER_SPAN(DITHER_SPAN)) u_osc (
    .clk(clk), .rst_n(rst_n), .hold_flat(src_q == SRC_EXT), .tick(int_tick)
  );

  pgs_ext_mon #(.EXT_TIMEOUT(EXT_TIMEOUT), .RELOCK_EDGES(RELOCK_EDGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_edge(ext_edge), .ext_req(ext_req)
  );

  // Source changes only on an internal phase boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        src_q <= SRC_INT;
    else if (int_tick) src_q <= ext_req ? SRC_EXT : SRC_INT;
  end

  assign sel_tick = (src_q == SRC_EXT) ? ext_edge : int_tick;

  pgs_bbm #(.DEAD_CYC(DEAD_CYC)) u_bbm (
    .clk(clk), .rst_n(rst_n), .act(act_q), .tick(sel_tick), .g1(g1), .g2(g2)
  );

  pgs_softstart #(.SS_STEP(SS_STEP), .SS_W(SS_W)) u_ss (
    .clk(clk), .rst_n(rst_n), .act(act_q), .level(ss_level)
  );

  assign drive_en = act_q;
  assign clk_src  = (src_q == SRC_EXT);

  AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src != $past(clk_src)) |-> $past(int_tick)); // R5
  AST_LOCK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_src) |-> $past(ext_req)); // R5
  AST_FALLBACK_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_src) |-> $past(!ext_req)); // R4

endmodule

// File: tb/pp_gate_seq_tb.sv
`timescale 1ns/1ps
module pp_gate_seq_tb;
  localparam int BASE = 20, SPAN = 4, DEAD = 3, TMO = 64, RELOCK = 3;
  localparam int SS_STEP = 8, SS_W = 4, EXT_P = 24;
  localparam int SS_MAX = (1 << SS_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, uvlo = 1'b0, ext_clk = 1'b0;
  logic g1, g2, drive_en, clk_src;
  logic [SS_W-1:0] ss_level;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  pp_gate_seq #(.BASE_HALF(BASE), .DITHER_SPAN(SPAN), .DEAD_CYC(DEAD), .EXT_TIMEOUT(TMO),
                .RELOCK_EDGES(RELOCK), .SS_STEP(SS_STEP), .SS_W(SS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .uvlo(uvlo), .ext_clk(ext_clk),
    .g1(g1), .g2(g2), .drive_en(drive_en), .ss_level(ss_level), .clk_src(clk_src)
  );

  task automatic chk(input bit ok, input string req, input string what, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  // External clock generator: toggles every EXT_P/2 system clocks while enabled.
  bit ext_run = 1'b0;
  int ext_rises = 0;
  initial begin : ext_drv
    int half_cnt;
    half_cnt = 0;
    forever begin
      @(posedge clk); #1;
      if (ext_run) begin
        half_cnt++;
        if (half_cnt >= EXT_P / 2) begin
          half_cnt = 0;
          ext_clk = ~ext_clk;
          if (ext_clk) ext_rises++;
        end
      end else begin
        half_cnt = 0;
        ext_clk = 1'b0;
      end
    end
  end

  // Output monitor, sampled on the falling edge.
  int ovl_err = 0, gap_err = 0, alt_err = 0, adj_err = 0;
  int lowrun = 1000, h1 = 0, h2 = 0, last_rise = 0, rise_cnt = 0, prev_len = 0;
  int min1 = 999, max1 = 0, min2 = 999, max2 = 0;
  bit ign1 = 1'b1, ign2 = 1'b1, src_seen1 = 1'b0;
  logic pg1 = 1'b0, pg2 = 1'b0;

  task automatic note_len(input int len, input int which);
    if (which == 1) begin
      if (ign1) begin ign1 = 1'b0; return; end
      if (len < min1) min1 = len;
      if (len > max1) max1 = len;
    end else begin
      if (ign2) begin ign2 = 1'b0; return; end
      if (len < min2) min2 = len;
      if (len > max2) max2 = len;
    end
    if (prev_len > 0 && ((len > prev_len) ? len - prev_len : prev_len - len) > 1) adj_err++;
    prev_len = len;
  endtask

  always @(negedge clk) begin
    if (g1 && g2) ovl_err++;
    if ((g1 && !pg1) || (g2 && !pg2)) begin
      if (lowrun < DEAD + 1) gap_err++;
      rise_cnt++;
      if (g1 && !pg1) begin
        if (last_rise == 1) alt_err++;
        last_rise = 1;
      end else begin
        if (last_rise == 2) alt_err++;
        last_rise = 2;
      end
    end
    if (!g1 && !g2) lowrun++; else lowrun = 0;
    if (g1) h1++; else if (pg1) begin note_len(h1, 1); h1 = 0; end
    if (g2) h2++; else if (pg2) begin note_len(h2, 2); h2 = 0; end
    if (clk_src) src_seen1 = 1'b1;
    pg1 = g1;
    pg2 = g2;
  end

  task automatic clr_stats();
    min1 = 999; max1 = 0; min2 = 999; max2 = 0;
    ign1 = 1'b1; ign2 = 1'b1; prev_len = 0;
    alt_err = 0; last_rise = 0; rise_cnt = 0; adj_err = 0; src_seen1 = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; uvlo = 1'b0;
    repeat (3) @(negedge clk);
    chk(!g1 && !g2, "R10", "gates in reset", int'(g1) + int'(g2), 0);
    chk(!drive_en && ss_level == 0, "R10", "drive_en/ss_level in reset", int'(drive_en) + int'(ss_level), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_src == 1'b0, "R10", "clk_src after reset (R11 internal=0)", int'(clk_src), 0);
    chk(!drive_en && ss_level == 0, "R10", "outputs after reset", int'(drive_en) + int'(ss_level), 0);
  endtask

  // Activation ramp; the caller has just released en or uvlo on a falling edge.
  task automatic t_ramp(input string tag);
    int n_hit;
    bit mono;
    int prev;
    n_hit = -1; mono = 1'b1; prev = 0;
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      if (n == 1) chk(drive_en == 1'b1, "R8", {tag, " drive_en one clock after activation"}, int'(drive_en), 1);
      if (int'(ss_level) < prev || int'(ss_level) > prev + 1) mono = 1'b0;
      prev = int'(ss_level);
      if (ss_level == SS_W'(SS_MAX) && n_hit < 0) n_hit = n;
    end
    chk(mono, "R9", {tag, " ss_level steps by one"}, int'(mono), 1);
    chk(n_hit == SS_STEP * SS_MAX + 1, "R9", {tag, " cycles to full scale"}, n_hit, SS_STEP * SS_MAX + 1);
    chk(ss_level == SS_W'(SS_MAX), "R9", {tag, " ss_level holds full scale"}, int'(ss_level), SS_MAX);
  endtask

  task automatic t_internal();
    clr_stats();
    repeat (1000) @(negedge clk);
    chk(clk_src == 1'b0, "R11", "internal source selected", int'(clk_src), 0);
    chk(min1 == BASE - SPAN - DEAD - 1, "R6", "shortest g1 high", min1, BASE - SPAN - DEAD - 1);
    chk(max1 == BASE + SPAN - DEAD - 1, "R6", "longest g1 high", max1, BASE + SPAN - DEAD - 1);
    chk(min2 == BASE - SPAN - DEAD - 1, "R6", "shortest g2 high", min2, BASE - SPAN - DEAD - 1);
    chk(max2 == BASE + SPAN - DEAD - 1, "R6", "longest g2 high", max2, BASE + SPAN - DEAD - 1);
    chk(adj_err == 0, "R6", "consecutive high times differ by <=1", adj_err, 0);
    chk(alt_err == 0, "R1", "gates alternate (internal)", alt_err, 0);
    chk(rise_cnt >= 40, "R1", "gate rises in 1000 cycles", rise_cnt, 40);
  endtask

  task automatic t_external();
    ext_rises = 0;
    ext_run = 1'b1;
    repeat (150) @(negedge clk);
    chk(clk_src == 1'b1, "R5", "locked to external (R11 external=1)", int'(clk_src), 1);
    repeat (60) @(negedge clk);
    clr_stats();
    repeat (400) @(negedge clk);
    chk(min1 == EXT_P - DEAD - 1 && max1 == EXT_P - DEAD - 1, "R2", "g1 high in external mode", max1, EXT_P - DEAD - 1);
    chk(min2 == EXT_P - DEAD - 1 && max2 == EXT_P - DEAD - 1, "R7", "g2 high constant, no dither", min2, EXT_P - DEAD - 1);
    chk(alt_err == 0, "R1", "gates alternate (external)", alt_err, 0);
  endtask

  task automatic t_fallback();
    ext_run = 1'b0;
    repeat (30) @(negedge clk);
    chk(clk_src == 1'b1, "R4", "still external before timeout", int'(clk_src), 1);
    repeat (100) @(negedge clk);
    chk(clk_src == 1'b0, "R4", "fell back to internal", int'(clk_src), 0);
    clr_stats();
    repeat (200) @(negedge clk);
    chk(rise_cnt >= 4, "R4", "gates switch after fallback", rise_cnt, 4);
  endtask

  task automatic t_short_train();
    clr_stats();
    ext_rises = 0;
    ext_run = 1'b1;
    while (ext_rises < RELOCK - 1) @(negedge clk);
    ext_run = 1'b0;
    repeat (250) @(negedge clk);
    chk(src_seen1 == 1'b0, "R5", "short edge train does not relock", int'(src_seen1), 0);
  endtask

  task automatic t_disable();
    int bad;
    en = 1'b0;
    @(negedge clk);
    chk(drive_en == 1'b0, "R8", "drive_en off one clock after en low", int'(drive_en), 0);
    @(negedge clk);
    chk(!g1 && !g2, "R8", "gates off after en low", int'(g1) + int'(g2), 0);
    chk(ss_level == 0, "R8", "ss_level cleared after en low", int'(ss_level), 0);
    bad = 0;
    repeat (50) begin
      @(negedge clk);
      if (g1 || g2 || drive_en || ss_level != 0) bad++;
    end
    chk(bad == 0, "R8", "outputs stay off while disabled", bad, 0);
    uvlo = 1'b1;
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!drive_en && !g1 && !g2 && ss_level == 0, "R8", "uvlo holds outputs off",
        int'(drive_en) + int'(g1) + int'(g2) + int'(ss_level), 0);
    uvlo = 1'b0;
    t_ramp("re-enable");
    clr_stats();
    repeat (200) @(negedge clk);
    chk(rise_cnt >= 4, "R8", "gates resume after re-activation", rise_cnt, 4);
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    en = 1'b1;
    t_ramp("power-up");
    t_internal();
    t_external();
    t_fallback();
    t_short_train();
    t_disable();
    chk(ovl_err == 0, "R3", "cycles with both gates high", ovl_err, 0);
    chk(gap_err == 0, "R3", "rises without full dead time", gap_err, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule